// File: doc/BRIEF.md
# Single-Precision Compare with Condition Flag

This block compares two 32-bit IEEE-754 single-precision values under a relation chosen by a 3-bit code. The outcome goes into a one-bit condition flag register. Only a compare strobe writes that flag, and it keeps its value for as long as no compare strobe arrives. A branch stage asks a question later, either "branch if the flag is set" or "branch if the flag is clear", and gets back a combinational take-branch answer built from the stored flag.

The operands are classified first. An operand is NaN when its exponent field (bits 30:23) is all ones and its fraction field (bits 22:0) is nonzero. An all-ones exponent with a zero fraction is an infinity, and an infinity is ordered like any other number. Non-NaN operands are ordered by sign and magnitude, and the two zeros count as equal. Any NaN makes the pair unordered.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `cond_flag` is 0.
- R2: Code 0 (equal) stores 1 when the operands are bit-identical non-NaN values, or when both are zeros of either sign; otherwise it stores 0.
- R3: Code 1 (not equal) stores the inverse of the code-0 result, so it stores 1 whenever either operand is NaN.
- R4: Code 2 (less) and code 3 (less or equal) order non-NaN operands by sign and magnitude. A negative operand is below a positive one, and between two negatives the larger magnitude is smaller. Infinities sit at the ends.
- R5: Code 4 (greater) and code 5 (greater or equal) use the same ordering with the operands swapped.
- R6: When either operand is NaN (exponent bits 30:23 all ones and fraction bits 22:0 nonzero), codes 0, 2, 3, 4 and 5 store 0.
- R7: When `cmp_en` is low, or the code is 6 or 7, `cond_flag` keeps its value.
- R8: `take_branch` equals `br_query & (br_on_set ? cond_flag : ~cond_flag)`, so it is 0 whenever `br_query` is low.
- R9: The flag changes on the clock edge that samples `cmp_en`. A branch query in that same cycle sees the previous flag, and a query in the next cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | Left operand, single precision |
| op_b | input | 32 | Right operand, single precision |
| rel_code | input | 3 | Relation: 0 eq, 1 ne, 2 lt, 3 le, 4 gt, 5 ge, 6-7 no effect |
| cmp_en | input | 1 | Compare strobe; writes the flag |
| br_query | input | 1 | Branch decision request |
| br_on_set | input | 1 | 1: branch if flag set; 0: branch if flag clear |
| cond_flag | output | 1 | Stored condition flag |
| take_branch | output | 1 | Branch decision |

## Verification
The assertions assume that operands and codes are stable around the sampling edge. They also assume that `cmp_en` and `br_query` are clean single-bit levels that are never X once reset has been released. The bench drives every input on the falling edge and releases reset before any strobe, so each compare is seen on exactly one rising edge. The operands are chosen from a fixed set: signed zeros, unit values, infinities and a quiet NaN. All of them are well defined, so every relation has a single expected answer.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int MAG_W   = FP_W - 1;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_LT = 3'd2,
        REL_LE = 3'd3,
        REL_GT = 3'd4,
        REL_GE = 3'd5,
        REL_R6 = 3'd6,
        REL_R7 = 3'd7
    } rel_e;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_zero;
        logic             is_inf;
        logic [MAG_W-1:0] mag;
    } fp_class_t;

    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
        logic gt;
    } order_t;

    typedef struct packed {
        logic flag;
    } flag_state_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int W  = FP_W,
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [W-1:0] value,
    output fp_class_t    cls
);
    localparam int EXP_LO = FW;
    localparam int EXP_HI = FW + EW - 1;

    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          exp_ones;

    always_comb begin
        exp_f        = value[EXP_HI:EXP_LO];
        frac_f       = value[FW-1:0];
        exp_ones     = &exp_f;
        cls.sign     = value[W-1];
        cls.mag      = value[W-2:0];
        cls.is_nan   = exp_ones && (frac_f != '0);
        cls.is_inf   = exp_ones && (frac_f == '0);
        cls.is_zero  = (value[W-2:0] == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_class_t a,
    input  fp_class_t b,
    output order_t    ord
);
    logic both_zero;
    logic same_bits;
    logic mag_lt;
    logic mag_gt;
    logic raw_lt;

    always_comb begin
        both_zero = a.is_zero && b.is_zero;
        same_bits = (a.sign == b.sign) && (a.mag == b.mag);
        mag_lt    = a.mag < b.mag;
        mag_gt    = a.mag > b.mag;
        if (a.sign != b.sign) begin
            raw_lt = a.sign;
        end else if (a.sign) begin
            raw_lt = mag_gt;
        end else begin
            raw_lt = mag_lt;
        end
        ord.unord = a.is_nan || b.is_nan;
        ord.eq    = !ord.unord && (both_zero || same_bits);
        ord.lt    = !ord.unord && !both_zero && !same_bits && raw_lt;
        ord.gt    = !ord.unord && !ord.eq && !ord.lt;
    end
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
    import fcmp_pkg::*;
(
    input  order_t            ord,
    input  logic [CODE_W-1:0] code,
    output logic              result,
    output logic              code_ok
);
    always_comb begin
        result  = 1'b0;
        code_ok = 1'b1;
        unique case (rel_e'(code))
            REL_EQ: result = ord.eq;
            REL_NE: result = !ord.eq;
            REL_LT: result = ord.lt;
            REL_LE: result = ord.lt || ord.eq;
            REL_GT: result = ord.gt;
            REL_GE: result = ord.gt || ord.eq;
            default: code_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FP_W-1:0]   op_a,
    input  logic [FP_W-1:0]   op_b,
    input  logic [CODE_W-1:0] rel_code,
    input  logic              cmp_en,
    input  logic              br_query,
    input  logic              br_on_set,
    output logic              cond_flag,
    output logic              take_branch
);
    localparam int N_OPS = 2;

    fp_class_t   cls [N_OPS];
    order_t      ord;
    logic        rel_result;
    logic        rel_ok;
    flag_state_t st_d;
    flag_state_t st_q;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_cls
            fcmp_classify #(.W(FP_W), .EW(EXP_W), .FW(FRAC_W)) u_cls (
                .value (gi == 0 ? op_a : op_b),
                .cls   (cls[gi])
            );
        end
    endgenerate

    fcmp_order u_ord (
        .a   (cls[0]),
        .b   (cls[1]),
        .ord (ord)
    );

    fcmp_relation u_rel (
        .ord     (ord),
        .code    (rel_code),
        .result  (rel_result),
        .code_ok (rel_ok)
    );

    always_comb begin
        st_d = st_q;
        if (cmp_en && rel_ok) begin
            st_d.flag = rel_result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cond_flag   = st_q.flag;
    assign take_branch = br_query && (br_on_set ? st_q.flag : !st_q.flag);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(cond_flag)); // R7
    AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && rel_code[2] && rel_code[1]) |=> $stable(cond_flag)); // R7
    AST_NAN_NOT_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (cls[0].is_nan || cls[1].is_nan) && rel_code == 3'd0) |=> !cond_flag); // R6
    AST_NAN_NE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (cls[0].is_nan || cls[1].is_nan) && rel_code == 3'd1) |=> cond_flag); // R3
    AST_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cls[0].is_zero && cls[1].is_zero && rel_code == 3'd0) |=> cond_flag); // R2
    AST_NO_QUERY_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        !br_query |-> !take_branch); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !cond_flag); // R1
endmodule

// File: tb/fcmp_cond_unit_tb_top.sv
module fcmp_cond_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  rel_code = '0;
    logic        cmp_en = 1'b0;
    logic        br_query = 1'b0;
    logic        br_on_set = 1'b0;
    logic        cond_flag;
    logic        take_branch;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fcmp_cond_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .rel_code(rel_code), .cmp_en(cmp_en), .br_query(br_query),
        .br_on_set(br_on_set), .cond_flag(cond_flag), .take_branch(take_branch)
    );

    localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
    localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
    localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
    localparam logic [31:0] PI = 32'h7F800000, NI = 32'hFF800000;
    localparam logic [31:0] QN = 32'h7FC00000;

    localparam int NV = 22;
    localparam logic [67:0] VEC [NV] = '{
        {P1, P1, 3'd0, 1'b1}, {P1, P2, 3'd0, 1'b0}, {PZ, NZ, 3'd0, 1'b1},
        {P1, P2, 3'd1, 1'b1}, {QN, QN, 3'd1, 1'b1}, {P1, P2, 3'd2, 1'b1},
        {P2, P1, 3'd2, 1'b0}, {N2, N1, 3'd2, 1'b1}, {N1, P1, 3'd2, 1'b1},
        {P1, P1, 3'd3, 1'b1}, {N1, N2, 3'd3, 1'b0}, {P2, P1, 3'd4, 1'b1},
        {N1, N2, 3'd4, 1'b1}, {NZ, PZ, 3'd4, 1'b0}, {P1, P1, 3'd5, 1'b1},
        {NI, N2, 3'd5, 1'b0}, {PI, P2, 3'd4, 1'b1}, {QN, P1, 3'd0, 1'b0},
        {QN, P1, 3'd2, 1'b0}, {P1, QN, 3'd5, 1'b0}, {QN, P1, 3'd3, 1'b0},
        {QN, N1, 3'd4, 1'b0}
    };

    function automatic string tag_of(logic [31:0] a, logic [31:0] b, logic [2:0] c);
        if ((a[30:23] == 8'hFF && a[22:0] != 0 || b[30:23] == 8'hFF && b[22:0] != 0) && c != 3'd1)
            return "R6";
        case (c)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic compare(logic [31:0] a, logic [31:0] b, logic [2:0] c);
        op_a = a; op_b = b; rel_code = c; cmp_en = 1'b1;
        @(negedge clk);
        cmp_en = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", cond_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", cond_flag, 1'b0);

        for (int i = 0; i < NV; i++) begin
            compare(VEC[i][67:36], VEC[i][35:4], VEC[i][3:1]);
            check(tag_of(VEC[i][67:36], VEC[i][35:4], VEC[i][3:1]), cond_flag, VEC[i][0]);
        end

        // R7: codes 6 and 7 and an idle strobe keep the flag
        compare(P1, P1, 3'd0);
        compare(P1, P2, 3'd6);
        check("R7", cond_flag, 1'b1);
        compare(P1, P2, 3'd0);
        compare(P1, P1, 3'd7);
        check("R7", cond_flag, 1'b0);
        op_a = P1; op_b = P1; rel_code = 3'd0; cmp_en = 1'b0;
        @(negedge clk);
        check("R7", cond_flag, 1'b0);

        // R8: branch decision for both selectors
        br_query = 1'b1; br_on_set = 1'b1; #1;
        check("R8", take_branch, 1'b0);
        br_on_set = 1'b0; #1;
        check("R8", take_branch, 1'b1);
        br_query = 1'b0; #1;
        check("R8", take_branch, 1'b0);
        compare(P1, P1, 3'd0);
        br_query = 1'b1; br_on_set = 1'b1; #1;
        check("R8", take_branch, 1'b1);
        br_on_set = 1'b0; #1;
        check("R8", take_branch, 1'b0);

        // R9: query in the compare cycle sees the old flag
        @(negedge clk);
        compare(P1, P2, 3'd0);
        br_on_set = 1'b1;
        op_a = P1; op_b = P1; rel_code = 3'd3; cmp_en = 1'b1; #1;
        check("R9", take_branch, 1'b0);
        @(negedge clk);
        cmp_en = 1'b0; #1;
        check("R9", take_branch, 1'b1);
        check("R9", cond_flag, 1'b1);
        br_query = 1'b0;

        // R1: reset clears a set flag
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", cond_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule